// File: doc/BRIEF.md
# Dual-Channel Link Failover Selector

This block chooses which of two network channels carries a management sideband session. It takes one raw link-up indication per channel. It filters each one through a debouncer whose settling time is set at run time. From the two filtered states and a two-bit policy input, it keeps a registered channel selection.

The selection comes out as a one-hot pair of enables, or all zero when no channel can be used. A one-cycle re-establish request goes with every move to a new channel, so the session layer knows to rebuild the session on that channel. The debounced link states are also driven out as status.

Three policies are offered:
- **First-up sticky:** holds whichever channel came up first for as long as it stays up.
- **Prefer channel 1:** always moves to channel 1 when it is up.
- **Prefer channel 2:** always moves to channel 2 when it is up.

In every policy, when the selected link drops, the selection fails over to the other channel if that channel is up. All pins are plain level control and status signals. There is no streamed data, so no valid/ready handshake applies.

Top module: `link_failover_sel`

## Requirements
- R1: `sel_o` never has more than one bit set. Bit 0 enables channel 1 and bit 1 enables channel 2.
- R2: `link_stat_o[i]` takes the value of `link_up_i[i]` at the N-th consecutive rising edge at which the two differ, where N is `db_limit_i`, or 1 when `db_limit_i` is 0. An edge at which they agree restarts the count.
- R3: `sel_o` is registered. It reflects the `link_stat_o`, `mode_i` and `sel_o` values present before the previous rising edge. A change of `mode_i` therefore takes effect on the next cycle.
- R4: With `mode_i` = 0 (first-up sticky), the selected channel is kept while its `link_stat_o` bit stays 1, even if the other channel is up.
- R5: With `mode_i` = 0 and the selected channel not up, channel 1 is chosen if it is up, otherwise channel 2 if it is up. When both come up in the same cycle from none selected, channel 1 wins.
- R6: With `mode_i` = 1, `sel_o` becomes 2'b01 whenever channel 1 is up, and 2'b10 only when channel 1 is down and channel 2 is up.
- R7: With `mode_i` = 2, `sel_o` becomes 2'b10 whenever channel 2 is up, and 2'b01 only when channel 2 is down and channel 1 is up.
- R8: When the selected channel's status drops while the other channel is up, the selection moves to the other channel on the next cycle, in every mode.
- R9: When both `link_stat_o` bits are 0, `sel_o` becomes 2'b00 on the next cycle, with no re-establish request.
- R10: `reconnect_o` is 1 for exactly the first cycle in which `sel_o` shows a new non-zero value, and is 0 in every other cycle. A move to 2'b00 gives no request.
- R11: `mode_i` = 3 behaves exactly like mode 0.
- R12: While `rst_n` is low, `sel_o`, `reconnect_o` and `link_stat_o` are all 0 and the debounce counts are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 2 | Raw link-up per channel (bit 0 = channel 1) |
| mode_i | input | 2 | Policy: 0 first-up sticky, 1 prefer ch1, 2 prefer ch2, 3 as 0 |
| db_limit_i | input | CNT_W | Debounce length in cycles (0 treated as 1) |
| link_stat_o | output | 2 | Debounced link state per channel |
| sel_o | output | 2 | One-hot channel enable, 2'b00 when none |
| reconnect_o | output | 1 | One-cycle session re-establish request |

## Verification
Two events can fall in the same cycle:
- a debounced link edge, which triggers failover or a policy move;
- a change of `mode_i`, which triggers re-evaluation.

Both then feed the same selection register in one evaluation. The bench provokes this with directed steps:
- raising both links together, so both debouncers settle at the same edge;
- flipping the mode while a link is settling.

Random stimulus then lets link toggles, glitches shorter than the debounce length, mode flips and debounce-length changes collide freely. Each cycle is judged against a bench model of the requirements. The model compares the status, the selection and the re-establish pulse together, so a same-cycle collision must yield one consistent channel and at most one pulse.

// File: rtl/fo_pkg.sv
package fo_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    POL_FIRST = 2'd0,
    POL_PREF1 = 2'd1,
    POL_PREF2 = 2'd2,
    POL_ALT0  = 2'd3
  } fo_policy_e;

  localparam logic [NUM_CH-1:0] SEL_NONE = 2'b00;
  localparam logic [NUM_CH-1:0] SEL_CH1  = 2'b01;
  localparam logic [NUM_CH-1:0] SEL_CH2  = 2'b10;
endpackage

// File: rtl/link_debounce.sv
module link_debounce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             stat_o
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_n;
  logic [CNT_W:0]   lim_eff;
  logic             stat_q;

  // consecutive disagreeing edges, including the current one
  assign run_n   = {1'b0, run_q} + {{CNT_W{1'b0}}, 1'b1};
  assign lim_eff = (limit_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      run_q  <= '0;
    end else if (raw_i != stat_q) begin
      if (run_n >= lim_eff) begin
        stat_q <= raw_i;
        run_q  <= '0;
      end else begin
        run_q  <= run_n[CNT_W-1:0];
      end
    end else begin
      run_q <= '0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/fo_policy.sv
module fo_policy
  import fo_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [NUM_CH-1:0] stat_i,
  input  logic [NUM_CH-1:0] cur_i,
  output logic [NUM_CH-1:0] nxt_o
);
  logic [NUM_CH-1:0] first_pick;
  logic              keep_cur;

  // sticky policy holds the current channel while its link is up
  assign keep_cur   = (cur_i == SEL_CH1 && stat_i[0]) || (cur_i == SEL_CH2 && stat_i[1]);
  assign first_pick = stat_i[0] ? SEL_CH1 : (stat_i[1] ? SEL_CH2 : SEL_NONE);

  always_comb begin
    unique case (fo_policy_e'(mode_i))
      POL_PREF1: nxt_o = first_pick;
      POL_PREF2: nxt_o = stat_i[1] ? SEL_CH2 : (stat_i[0] ? SEL_CH1 : SEL_NONE);
      default:   nxt_o = keep_cur ? cur_i : first_pick;
    endcase
  end
endmodule

// File: rtl/link_failover_sel.sv
module link_failover_sel
  import fo_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       link_up_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] db_limit_i,
  output logic [1:0]       link_stat_o,
  output logic [1:0]       sel_o,
  output logic             reconnect_o
);
  logic [NUM_CH-1:0] stat_w;
  logic [NUM_CH-1:0] nxt_sel;
  logic [NUM_CH-1:0] sel_q;
  logic              rec_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_db
    link_debounce #(.CNT_W(CNT_W)) u_db (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (link_up_i[g]),
      .limit_i (db_limit_i),
      .stat_o  (stat_w[g])
    );
  end

  fo_policy u_pol (
    .mode_i (mode_i),
    .stat_i (stat_w),
    .cur_i  (sel_q),
    .nxt_o  (nxt_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_NONE;
      rec_q <= 1'b0;
    end else begin
      sel_q <= nxt_sel;
      rec_q <= (nxt_sel != sel_q) && (nxt_sel != SEL_NONE);
    end
  end

  assign link_stat_o = stat_w;
  assign sel_o       = sel_q;
  assign reconnect_o = rec_q;
endmodule

// File: rtl/link_failover_sel_chk.sv
module link_failover_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] link_up_i,
  input logic [1:0] mode_i,
  input logic [1:0] link_stat_o,
  input logic [1:0] sel_o,
  input logic       reconnect_o
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  p_stat_ch1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_stat_o[0] != $past(link_stat_o[0])) |-> (link_stat_o[0] == $past(link_up_i[0])));

  p_stat_ch2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_stat_o[1] != $past(link_stat_o[1])) |-> (link_stat_o[1] == $past(link_up_i[1])));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && sel_o == 2'b10 && link_stat_o[1]) |=> (sel_o == 2'b10));

  p_pref1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && link_stat_o[0]) |=> (sel_o == 2'b01));

  p_pref2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && link_stat_o[1]) |=> (sel_o == 2'b10));

  p_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_stat_o == 2'b00) |=> (sel_o == 2'b00 && !reconnect_o));

  p_pulse_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reconnect_o |-> (sel_o != 2'b00 && sel_o != $past(sel_o)));

  p_pulse_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != $past(sel_o) && sel_o != 2'b00) |-> reconnect_o);
endmodule

bind link_failover_sel link_failover_sel_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_up_i   (link_up_i),
  .mode_i      (mode_i),
  .link_stat_o (link_stat_o),
  .sel_o       (sel_o),
  .reconnect_o (reconnect_o)
);

// File: tb/sim_link_failover_sel.sv
module sim_link_failover_sel;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    link_up_i;
  logic [1:0]    mode_i;
  logic [CW-1:0] db_limit_i;
  logic [1:0]    link_stat_o;
  logic [1:0]    sel_o;
  logic          reconnect_o;

  always #10 clk = ~clk;

  link_failover_sel #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i), .mode_i(mode_i),
    .db_limit_i(db_limit_i), .link_stat_o(link_stat_o), .sel_o(sel_o),
    .reconnect_o(reconnect_o)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // reference model built from the requirements
  logic [1:0] m_stat;
  int         m_cnt [2];
  logic [1:0] m_sel;
  logic       m_rec;

  function automatic logic [1:0] want_sel(logic [1:0] md, logic [1:0] st, logic [1:0] cur);
    if (md == 2'd1) return st[0] ? 2'b01 : (st[1] ? 2'b10 : 2'b00);
    if (md == 2'd2) return st[1] ? 2'b10 : (st[0] ? 2'b01 : 2'b00);
    if (cur == 2'b01 && st[0]) return 2'b01;
    if (cur == 2'b10 && st[1]) return 2'b10;
    return st[0] ? 2'b01 : (st[1] ? 2'b10 : 2'b00);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat <= 2'b00; m_cnt[0] <= 0; m_cnt[1] <= 0; m_sel <= 2'b00; m_rec <= 1'b0;
    end else begin
      logic [1:0] nx;
      int lim;
      lim = (db_limit_i == 0) ? 1 : int'(db_limit_i);
      for (int i = 0; i < 2; i++) begin
        if (link_up_i[i] != m_stat[i]) begin
          if (m_cnt[i] + 1 >= lim) begin m_stat[i] <= link_up_i[i]; m_cnt[i] <= 0; end
          else m_cnt[i] <= m_cnt[i] + 1;
        end else m_cnt[i] <= 0;
      end
      nx = want_sel(mode_i, m_stat, m_sel);
      m_sel <= nx;
      m_rec <= (nx != m_sel) && (nx != 2'b00);
    end
  end

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R12 reset sel", sel_o, 2'b00);
        chk("R12 reset status", link_stat_o, 2'b00);
        chk("R12 reset pulse", {1'b0, reconnect_o}, 2'b00);
      end else begin
        chk("R2 debounced status", link_stat_o, m_stat);
        chk(mode_i == 2'd1 ? "R6 R3 sel" : mode_i == 2'd2 ? "R7 R3 sel" :
            mode_i == 2'd3 ? "R11 sel" : "R4 R5 R8 sel", sel_o, m_sel);
        chk("R10 R9 reconnect", {1'b0, reconnect_o}, {1'b0, m_rec});
        chk("R1 one-hot", {1'b0, ($countones(sel_o) > 1)}, 2'b00);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; link_up_i = 2'b00; mode_i = 2'd0; db_limit_i = 8'd3;
    step(4);
    rst_n = 1'b1;
    step(2);
    // R5: both links rise together in sticky mode -> channel 1
    link_up_i = 2'b11;
    step(8);
    chk("R5 both up same cycle", sel_o, 2'b01);
    // R8: channel 1 drops -> failover to channel 2
    link_up_i = 2'b10;
    step(8);
    chk("R8 failover", sel_o, 2'b10);
    // R4: channel 1 returns, sticky keeps channel 2
    link_up_i = 2'b11;
    step(8);
    chk("R4 sticky hold", sel_o, 2'b10);
    // R6 / R7: mode switch re-evaluates on the next cycle (R3)
    mode_i = 2'd1;
    step(1);
    chk("R3 mode change next cycle", sel_o, 2'b01);
    mode_i = 2'd2;
    step(3);
    chk("R7 prefer ch2", sel_o, 2'b10);
    mode_i = 2'd1;
    step(3);
    chk("R6 prefer ch1", sel_o, 2'b01);
    // R9: both down -> none selected
    link_up_i = 2'b00;
    step(8);
    chk("R9 none", sel_o, 2'b00);
    // R11: mode 3 sticky like mode 0
    mode_i = 2'd3;
    link_up_i = 2'b10;
    step(8);
    link_up_i = 2'b11;
    step(8);
    chk("R11 alt sticky", sel_o, 2'b10);
    // R2: glitch shorter than debounce length is ignored
    link_up_i = 2'b00; db_limit_i = 8'd4;
    step(10);
    link_up_i = 2'b01;
    step(2);
    link_up_i = 2'b00;
    step(4);
    chk("R2 glitch ignored status", link_stat_o, 2'b00);
    chk("R2 glitch ignored sel", sel_o, 2'b00);
    // R2 boundary: limit 0 acts as 1
    db_limit_i = 8'd0;
    link_up_i = 2'b10;
    @(posedge clk); #2;
    chk("R2 limit zero", link_stat_o, 2'b10);
    // constrained random phase
    void'($urandom(32'h5eed));
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 39) == 0) link_up_i[0] = ~link_up_i[0];
      if ($urandom_range(0, 39) == 0) link_up_i[1] = ~link_up_i[1];
      if ($urandom_range(0, 299) == 0) mode_i = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 499) == 0) db_limit_i = CW'($urandom_range(0, 5));
      step(1);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule